// File: doc/BRIEF.md
# Relative-Indexed Constant Register File

This block holds a bank of four-lane constant vectors. A program reaches those vectors through a signed index register. A move operation loads the index register from a signed fixed-point operand. The load turns the operand into an integer by rounding toward minus infinity. A read operation adds an unsigned immediate to the index register and returns the selected vector one cycle later. An index that falls below zero or past the last entry does not wrap and does not fault. It returns a vector of zeros in every lane.

A host loads the constants through a synchronous write port before a program runs. A start-of-program pulse sets the index register back to zero. The index register has no read-back path. Its value can only be seen through the vectors that reads select.

Top module: `relidx_const_bank`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_data` is all zeros, the index register is 0, and every bank entry reads as all zeros.
- R2: When `host_we` is high at a clock edge and `host_addr` is below ENTRIES (96), that entry takes `host_data`. A write with `host_addr` of ENTRIES or more changes no entry.
- R3: When `mov_valid` is high and `prog_start` is low, the index register takes floor(`mov_value` / 256). Here `mov_value` is a two's-complement Q16.8 value: bits 23:8 hold the integer part and bits 7:0 the fraction. Positive fractions truncate, and negative fractions go to the next lower integer. With no move and no start, the index register holds its value.
- R4: A high `prog_start` clears the index register to 0 at the clock edge. It wins over a `mov_valid` in the same cycle.
- R5: A read request (`rd_en` high) uses the effective index, which is the index register plus `rd_imm` read as an unsigned 8-bit value. One cycle later `rd_valid` is high for exactly one cycle, and `rd_data` holds that entry. Lane 0 is in bits 31:0.
- R6: If the effective index is negative, or is ENTRIES (96) or more, the read returns all zeros in every lane.
- R7: In a cycle after one with no read request, `rd_valid` is low and `rd_data` keeps its last value.
- R8: A read uses the index register and bank contents from before the edge at which it is sampled. A move or a host write in the same cycle affects only later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_start | input | 1 | Start-of-program pulse that clears the index register |
| mov_valid | input | 1 | Load the index register from `mov_value` |
| mov_value | input | 24 | Signed Q16.8 move operand |
| host_we | input | 1 | Host constant write strobe |
| host_addr | input | 7 | Host write entry number |
| host_data | input | 128 | Host write vector, four 32-bit lanes |
| rd_en | input | 1 | Read request |
| rd_imm | input | 8 | Unsigned immediate added to the index register |
| rd_valid | output | 1 | Read result valid, one cycle after `rd_en` |
| rd_data | output | 128 | Read result vector |

## Verification
The bench drives negative operands with fractions, such as -1.75, which must give -2. A converter that truncated toward zero would return -1 and select the wrong entry. It reads at the indices just inside and just outside the bank: -1, 0, 95 and 96, plus the largest index plus the largest immediate. A range check done at the wrong width, or without looking at the sign, would wrap into the bank and return real constants instead of zeros. It also issues a start and a move in the same cycle, a read in the same cycle as a move, and a read of an entry in the same cycle as a host write to that entry. A wrong priority or a wrong bypass there would show up as an index or contents one step early or late. Finally, it writes to entry numbers past the end of the bank. An unguarded write would alias onto a real entry.

// File: rtl/relidx_pkg.sv
package relidx_pkg;

    // How a sampled read request resolves
    typedef enum logic [1:0] {
        RK_IDLE = 2'd0,
        RK_HIT  = 2'd1,
        RK_MISS = 2'd2
    } rd_kind_e;

endpackage

// File: rtl/relidx_floor.sv
// Signed fixed-point to integer, rounding toward minus infinity.
module relidx_floor #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8,
    localparam int FX_W  = INT_W + FRAC_W
) (
    input  logic [FX_W-1:0]  fx_in,
    output logic [INT_W-1:0] int_out
);

    generate
        if (FRAC_W == 0) begin : g_whole
            assign int_out = fx_in[INT_W-1:0];
        end else begin : g_split
            // Dropping two's-complement fraction bits is a floor for both signs
            logic unused_frac;
            assign unused_frac = ^fx_in[FRAC_W-1:0];
            assign int_out     = fx_in[FX_W-1:FRAC_W];
        end
    endgenerate

endmodule

// File: rtl/relidx_addr.sv
// Effective index = signed index + unsigned immediate, then bounds test.
module relidx_addr #(
    parameter int INT_W   = 16,
    parameter int IMM_W   = 8,
    parameter int ENTRIES = 96,
    localparam int AW     = $clog2(ENTRIES),
    localparam int EW     = ((INT_W > IMM_W) ? INT_W : IMM_W) + 2
) (
    input  logic [INT_W-1:0] idx,
    input  logic [IMM_W-1:0] imm,
    output logic             in_range,
    output logic [AW-1:0]    addr
);

    logic [EW-1:0] idx_ext;
    logic [EW-1:0] imm_ext;
    logic [EW-1:0] eff;
    logic          neg;
    logic          below_top;

    assign idx_ext   = {{(EW-INT_W){idx[INT_W-1]}}, idx};
    assign imm_ext   = {{(EW-IMM_W){1'b0}}, imm};
    assign eff       = idx_ext + imm_ext;
    assign neg       = eff[EW-1];
    assign below_top = eff[EW-2:0] < (EW-1)'(ENTRIES);
    assign in_range  = !neg && below_top;
    assign addr      = eff[AW-1:0];

endmodule

// File: rtl/relidx_bank.sv
// Constant storage: one synchronous write port, combinational read.
module relidx_bank #(
    parameter int ENTRIES = 96,
    parameter int DW      = 128,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word
);

    logic [DW-1:0] mem_q [ENTRIES];
    logic [DW-1:0] mem_d [ENTRIES];
    logic          wr_ok;
    logic          rd_ok;

    assign wr_ok = wr_en && ({1'b0, wr_addr} < (AW+1)'(ENTRIES));
    assign rd_ok = {1'b0, rd_addr} < (AW+1)'(ENTRIES);

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_ok) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_word = rd_ok ? mem_q[rd_addr] : '0;

endmodule

// File: rtl/relidx_const_bank.sv
module relidx_const_bank
    import relidx_pkg::*;
#(
    parameter int ENTRIES = 96,
    parameter int LANES   = 4,
    parameter int LANE_W  = 32,
    parameter int INT_W   = 16,
    parameter int FRAC_W  = 8,
    parameter int IMM_W   = 8,
    localparam int AW     = $clog2(ENTRIES),
    localparam int DW     = LANES * LANE_W,
    localparam int FX_W   = INT_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_start,
    input  logic             mov_valid,
    input  logic [FX_W-1:0]  mov_value,
    input  logic             host_we,
    input  logic [AW-1:0]    host_addr,
    input  logic [DW-1:0]    host_data,
    input  logic             rd_en,
    input  logic [IMM_W-1:0] rd_imm,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data
);

    typedef struct packed {
        logic [INT_W-1:0] idx;
        logic             valid;
        logic [DW-1:0]    data;
    } state_t;

    state_t st_d, st_q;

    logic [INT_W-1:0] mov_int;
    logic             in_range;
    logic [AW-1:0]    rd_addr;
    logic [DW-1:0]    bank_word;
    logic [DW-1:0]    lane_word;
    rd_kind_e         kind;
    logic [INT_W-1:0] idx_now;
    logic             oob_now;

    relidx_floor #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_floor (
        .fx_in   (mov_value),
        .int_out (mov_int)
    );

    relidx_addr #(.INT_W(INT_W), .IMM_W(IMM_W), .ENTRIES(ENTRIES)) u_addr (
        .idx      (st_q.idx),
        .imm      (rd_imm),
        .in_range (in_range),
        .addr     (rd_addr)
    );

    relidx_bank #(.ENTRIES(ENTRIES), .DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_we),
        .wr_addr (host_addr),
        .wr_data (host_data),
        .rd_addr (rd_addr),
        .rd_word (bank_word)
    );

    // Per-lane zero gate for misses
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign lane_word[g*LANE_W +: LANE_W] =
                (kind == RK_HIT) ? bank_word[g*LANE_W +: LANE_W] : '0;
        end
    endgenerate

    always_comb begin
        if (!rd_en)        kind = RK_IDLE;
        else if (in_range) kind = RK_HIT;
        else               kind = RK_MISS;
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (kind != RK_IDLE) begin
            st_d.valid = 1'b1;
            st_d.data  = lane_word;
        end
        if (prog_start) begin
            st_d.idx = '0;
        end else if (mov_valid) begin
            st_d.idx = mov_int;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.valid;
    assign rd_data  = st_q.data;
    assign idx_now  = st_q.idx;
    assign oob_now  = !in_range;

endmodule

// File: rtl/relidx_checker.sv
module relidx_checker #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8,
    parameter int DW     = 128,
    localparam int FX_W  = INT_W + FRAC_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prog_start,
    input logic             mov_valid,
    input logic [FX_W-1:0]  mov_value,
    input logic             rd_en,
    input logic             rd_valid,
    input logic [DW-1:0]    rd_data,
    input logic [INT_W-1:0] idx_now,
    input logic             oob_now
);

    assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> (idx_now == '0));

    assert_move_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mov_valid && !prog_start) |=> (idx_now == $past(mov_value[FX_W-1:FRAC_W])));

    assert_idx_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mov_valid && !prog_start) |=> $stable(idx_now));

    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && oob_now) |=> (rd_data == '0));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && $stable(rd_data)));

endmodule

bind relidx_const_bank relidx_checker #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W),
    .DW     (DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_start (prog_start),
    .mov_valid  (mov_valid),
    .mov_value  (mov_value),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .idx_now    (idx_now),
    .oob_now    (oob_now)
);

// File: tb/relidx_const_bank_test.sv
module relidx_const_bank_test;

    localparam int ENTRIES = 96;
    localparam int DW      = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         prog_start = 1'b0;
    logic         mov_valid = 1'b0;
    logic [23:0]  mov_value = '0;
    logic         host_we = 1'b0;
    logic [6:0]   host_addr = '0;
    logic [DW-1:0] host_data = '0;
    logic         rd_en = 1'b0;
    logic [7:0]   rd_imm = '0;
    logic         rd_valid;
    logic [DW-1:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    string phase = "R1";
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    relidx_const_bank uut (
        .clk(clk), .rst_n(rst_n), .prog_start(prog_start),
        .mov_valid(mov_valid), .mov_value(mov_value),
        .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
        .rd_en(rd_en), .rd_imm(rd_imm),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // ---------------- behavioural reference ----------------
    logic [DW-1:0] m_mem [ENTRIES];
    int            m_idx;
    logic          m_valid;
    logic [DW-1:0] m_data;
    string         m_tag;

    always @(posedge clk or negedge rst_n) begin
        int eff;
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) m_mem[i] = '0;
            m_idx = 0; m_valid = 1'b0; m_data = '0; m_tag = "R1";
        end else begin
            // R8: read sees old index and old contents
            if (rd_en) begin
                eff = m_idx + int'(rd_imm);
                m_valid = 1'b1;
                if (eff >= 0 && eff < ENTRIES) begin
                    m_data = m_mem[eff]; m_tag = "R5";
                end else begin
                    m_data = '0; m_tag = "R6";
                end
            end else begin
                m_valid = 1'b0; m_tag = "R7";
            end
            if (host_we && int'(host_addr) < ENTRIES) m_mem[host_addr] = host_data;
            if (prog_start) m_idx = 0;
            else if (mov_valid)
                m_idx = $rtoi($floor(real'($signed(mov_value)) / 256.0));
        end
    end

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s (%s) actual=%h expected=%h", req, phase, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(rd_valid == m_valid, m_tag, {127'b0, rd_valid}, {127'b0, m_valid});
            check(rd_data == m_data, m_tag, rd_data, m_data);
        end
    end

    task automatic cyc(input bit ps, input bit mv, input logic [23:0] mval,
                       input bit we, input logic [6:0] wa, input logic [DW-1:0] wd,
                       input bit re, input logic [7:0] imm);
        prog_start = ps; mov_valid = mv; mov_value = mval;
        host_we = we; host_addr = wa; host_data = wd;
        rd_en = re; rd_imm = imm;
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return {32'(32'hA500_0000 + i*4 + 3), 32'(32'hA500_0000 + i*4 + 2),
                32'(32'hA500_0000 + i*4 + 1), 32'(32'hA500_0000 + i*4)};
    endfunction

    task automatic mov(input logic [23:0] v);
        cyc(0, 1, v, 0, 0, '0, 0, 0);
    endtask

    task automatic rd(input logic [7:0] imm);
        cyc(0, 0, 0, 0, 0, '0, 1, imm);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, '0, 0, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(rd_valid == 1'b0, "R1", {127'b0, rd_valid}, '0);
        check(rd_data == '0, "R1", rd_data, '0);
        for (int i = 0; i < ENTRIES; i++) rd(8'(i));   // R1 bank empty

        phase = "R2";
        for (int i = 0; i < ENTRIES; i++) cyc(0, 0, 0, 1, 7'(i), pat(i), 0, 0);
        cyc(0, 0, 0, 1, 7'd100, {DW{1'b1}}, 0, 0);      // R2 ignored write
        cyc(0, 0, 0, 1, 7'd127, {DW{1'b1}}, 0, 0);
        for (int i = 0; i < ENTRIES; i++) rd(8'(i));
        idle();

        phase = "R3";
        mov(24'h000500); rd(0); rd(7);           // 5.0   -> 5
        mov(24'h0003C0); rd(0);                  // 3.75  -> 3
        mov(24'hFFFE40); rd(2); rd(3);           // -1.75 -> -2
        mov(24'hFFFF00); rd(1);                  // -1.0  -> -1
        idle(); idle(); rd(1);                   // index holds

        phase = "R6";
        mov(24'hFFFE40); rd(1); rd(0);           // -1, -2
        mov(24'h005F80); rd(0); rd(1);           // 95, 96
        mov(24'h7FFFFF); rd(8'd255);
        mov(24'h800000); rd(8'd255);
        mov(24'h000000); rd(8'd95); rd(8'd96); rd(8'd255);
        idle(); idle();                          // R7 hold after miss

        phase = "R4";
        mov(24'h001000); cyc(1, 0, 0, 0, 0, '0, 0, 0); rd(4);
        mov(24'h001000); cyc(1, 1, 24'h002000, 0, 0, '0, 0, 0); rd(4);

        phase = "R8";
        mov(24'h000A00);
        cyc(0, 1, 24'h001400, 0, 0, '0, 1, 0);   // reads entry 10
        rd(0);                                   // now entry 20
        cyc(0, 0, 0, 1, 7'd22, {DW{1'b0}} | 128'h1234, 1, 2);  // old 22
        rd(2);                                   // new 22
        idle(); idle();

        phase = "mix";
        for (int k = 0; k < 1500; k++) begin
            logic [23:0] v;
            v = 24'($signed(int'($urandom_range(0, 240*256)) - 60*256));
            cyc(($urandom_range(0, 19) == 0), ($urandom_range(0, 3) == 0), v,
                ($urandom_range(0, 7) == 0), 7'($urandom_range(0, 127)),
                {$urandom, $urandom, $urandom, $urandom},
                $urandom_range(0, 1) == 1,
                ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255))
                                            : 8'($urandom_range(0, 40)));
        end
        idle(); idle();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule